// File: doc/BRIEF.md
# Stack Processor I/O Port Block

This block sits between a small stack processor and the signals it reads and drives. When the core executes an input instruction it presents the port number (the old top of stack) and raises a read strobe. The block returns the byte of the selected source on a combinational read bus, and the core writes that byte back over the port number. When the core executes an output instruction it presents the port number and the data byte (the value under the top) and raises a write strobe. The block then updates the matching output register or fires the matching pulse.

The port map is set by parameters, so each build carries a fixed map:
- byte-wide input ports, each of which may have a one-cycle read acknowledge;
- one packed status port that gathers narrow flags at fixed bit positions;
- single-bit set-and-clear-on-read event latches;
- output registers of individual width, each with its own reset value and an optional one-cycle write strobe;
- strobe-only outputs that carry no data.

Port numbers outside the map read as zero and cause no action.

Top module: `stk_io_ports`

## Requirements
- R1: While `rd_op` is high and `port_sel` equals `IN_BASE+i`, `rd_data` equals byte i of `din` (byte i is `din[8i+7:8i]`) in the same cycle.
- R2: Reading port `PACK_PORT` returns `pack_bits` zero-extended, with bit k of the result equal to `pack_bits[k]`. With the default map, a full flag sits at bit 1 and an empty flag at bit 0.
- R3: A read of input port i whose bit in `ACK_MASK` is set drives `din_ack[i]` high for exactly the one cycle after the read cycle. Ports whose bit is clear never raise their acknowledge.
- R4: A write to port `OUT_BASE+j` loads `wr_data` ANDed with byte j of `OUT_MASK` into `dout` byte j at the clock edge that ends the write cycle. Bits outside the mask stay zero, and bytes that were not addressed keep their values.
- R5: For an output port whose bit in `WSTB_MASK` is set, `dout_wstb[j]` is high for exactly one cycle, and that cycle is the first one in which the new data shows on `dout`. Ports whose bit is clear never raise it.
- R6: A write to port `STB_BASE+s` drives `out_pulse[s]` high for exactly one cycle after the write edge. No data is stored for these ports.
- R7: A one-cycle pulse on `sr_set[k]` sets event latch k. Reading port `SR_BASE+k` returns the latch in bit 0 and zeros above it, and the read clears the latch.
- R8: If `sr_set[k]` is high in the same cycle as a read of latch k, the latch stays set after that cycle.
- R9: While `rst` is high and after it is released, every `dout` byte j holds byte j of `OUT_INIT` ANDed with its mask. All strobes, acknowledges and latches are zero.
- R10: A read of an unmapped port number returns 0x00. A write to an unmapped port number changes no output and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_op | input | 1 | Input instruction strobe from the core |
| wr_op | input | 1 | Output instruction strobe from the core |
| port_sel | input | 8 | Port number taken from the top of stack |
| wr_data | input | 8 | Byte to write, taken from the next stack entry |
| rd_data | output | 8 | Byte read from the selected input source |
| din | input | 8*NUM_DIN | Byte-wide input port sources |
| din_ack | output | NUM_DIN | One-cycle read acknowledge per input port |
| pack_bits | input | PACK_W | Narrow flags gathered into the packed status port |
| sr_set | input | NUM_SR | Set pulses for the event latches |
| dout | output | 8*NUM_DOUT | Output register contents |
| dout_wstb | output | NUM_DOUT | One-cycle write strobe per output port |
| out_pulse | output | NUM_STB | Strobe-only outputs |

## Verification
The bench uses the default map:
- two input bytes at ports 0 and 1, where only port 1 acknowledges;
- a two-flag status port at 2;
- event latches at 3 and 4;
- output registers of widths 1, 4 and 8 at ports 8 to 10, with reset value 0x0A on the 4-bit port and write strobes on ports 9 and 10;
- pulse outputs at ports 12 and 13.

It reads and then writes every one of the 256 port numbers. Each result is compared against an arithmetic model of the map. The sweeps therefore cover every mapped window edge, every unmapped number, the width masks and the strobe enables. Directed steps add the latch set, clear-on-read and collision cases, changes to the packed flags, and a reset applied after the outputs have been written.

// File: rtl/iop_pkg.sv
package iop_pkg;
    typedef logic [7:0] byte_t;

    // true when the selected port number equals base + idx
    function automatic logic port_hit(input byte_t sel, input int base, input int idx);
        return (int'(sel) == base + idx);
    endfunction
endpackage

// File: rtl/iop_read_path.sv
module iop_read_path
    import iop_pkg::*;
#(
    parameter int NUM_DIN   = 2,
    parameter int IN_BASE   = 0,
    parameter logic [NUM_DIN-1:0] ACK_MASK = '1,
    parameter int PACK_PORT = 2,
    parameter int PACK_W    = 2,
    parameter int NUM_SR    = 2,
    parameter int SR_BASE   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_op,
    input  byte_t                port_sel,
    input  logic [NUM_DIN*8-1:0] din,
    input  logic [PACK_W-1:0]    pack_bits,
    input  logic [NUM_SR-1:0]    sr_q,
    output byte_t                rd_data,
    output logic [NUM_DIN-1:0]   din_ack
);
    localparam int PAD_W = 8 - PACK_W;

    typedef struct packed {
        logic [NUM_DIN-1:0] ack;
    } rd_state_t;

    rd_state_t state_d, state_q;
    logic [NUM_DIN-1:0] din_hit;
    logic [NUM_SR-1:0]  sr_hit;
    logic               pack_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_DIN; gi++) begin : g_din_hit
            assign din_hit[gi] = port_hit(port_sel, IN_BASE, gi);
        end
        for (gi = 0; gi < NUM_SR; gi++) begin : g_sr_hit
            assign sr_hit[gi] = port_hit(port_sel, SR_BASE, gi);
        end
    endgenerate
    assign pack_hit = port_hit(port_sel, PACK_PORT, 0);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_DIN; i++) begin
            if (din_hit[i]) rd_data = din[i*8 +: 8];
        end
        if (pack_hit) rd_data = {{PAD_W{1'b0}}, pack_bits};
        for (int k = 0; k < NUM_SR; k++) begin
            if (sr_hit[k]) rd_data = {7'b0, sr_q[k]};
        end
        for (int i = 0; i < NUM_DIN; i++) begin
            state_d.ack[i] = ACK_MASK[i] & rd_op & din_hit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign din_ack = state_q.ack;

    generate
        for (gi = 0; gi < NUM_DIN; gi++) begin : g_ack_chk
            AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                (din_ack[gi] && !(rd_op && din_hit[gi])) |=> !din_ack[gi]); // R3
            AST_ACK_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
                (rd_op && din_hit[gi] && ACK_MASK[gi]) |=> din_ack[gi]); // R3
        end
    endgenerate
endmodule

// File: rtl/iop_sr_bits.sv
module iop_sr_bits
    import iop_pkg::*;
#(
    parameter int NUM_SR  = 2,
    parameter int SR_BASE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_op,
    input  byte_t             port_sel,
    input  logic [NUM_SR-1:0] sr_set,
    output logic [NUM_SR-1:0] sr_q
);
    typedef struct packed {
        logic [NUM_SR-1:0] bits;
    } sr_state_t;

    sr_state_t state_d, state_q;
    logic [NUM_SR-1:0] rd_hit;

    genvar gk;
    generate
        for (gk = 0; gk < NUM_SR; gk++) begin : g_hit
            assign rd_hit[gk] = rd_op & port_hit(port_sel, SR_BASE, gk);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < NUM_SR; k++) begin
            if (rd_hit[k]) state_d.bits[k] = 1'b0;
            // an arriving event takes priority over the clear
            if (sr_set[k]) state_d.bits[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign sr_q = state_q.bits;

    generate
        for (gk = 0; gk < NUM_SR; gk++) begin : g_chk
            AST_SR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                sr_set[gk] |=> sr_q[gk]); // R8
            AST_SR_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
                (rd_hit[gk] && !sr_set[gk]) |=> !sr_q[gk]); // R7
            AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!rd_hit[gk] && !sr_set[gk]) |=> $stable(sr_q[gk])); // R7
        end
    endgenerate
endmodule

// File: rtl/iop_write_path.sv
module iop_write_path
    import iop_pkg::*;
#(
    parameter int NUM_DOUT = 3,
    parameter int OUT_BASE = 8,
    parameter logic [NUM_DOUT*8-1:0] OUT_MASK  = '1,
    parameter logic [NUM_DOUT*8-1:0] OUT_INIT  = '0,
    parameter logic [NUM_DOUT-1:0]   WSTB_MASK = '1,
    parameter int NUM_STB  = 2,
    parameter int STB_BASE = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_op,
    input  byte_t                 port_sel,
    input  byte_t                 wr_data,
    output logic [NUM_DOUT*8-1:0] dout,
    output logic [NUM_DOUT-1:0]   dout_wstb,
    output logic [NUM_STB-1:0]    out_pulse
);
    localparam logic [NUM_DOUT*8-1:0] RESET_DATA = OUT_INIT & OUT_MASK;

    typedef struct packed {
        logic [NUM_DOUT*8-1:0] data;
        logic [NUM_DOUT-1:0]   wstb;
        logic [NUM_STB-1:0]    pulse;
    } wr_state_t;

    wr_state_t state_d, state_q;
    logic [NUM_DOUT-1:0] dout_hit;
    logic [NUM_STB-1:0]  stb_hit;

    genvar gj;
    generate
        for (gj = 0; gj < NUM_DOUT; gj++) begin : g_dout_hit
            assign dout_hit[gj] = wr_op & port_hit(port_sel, OUT_BASE, gj);
        end
        for (gj = 0; gj < NUM_STB; gj++) begin : g_stb_hit
            assign stb_hit[gj] = wr_op & port_hit(port_sel, STB_BASE, gj);
        end
    endgenerate

    always_comb begin
        state_d.data  = state_q.data;
        state_d.wstb  = '0;
        state_d.pulse = stb_hit;
        for (int j = 0; j < NUM_DOUT; j++) begin
            if (dout_hit[j]) begin
                state_d.data[j*8 +: 8] = wr_data & OUT_MASK[j*8 +: 8];
                state_d.wstb[j]        = WSTB_MASK[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.data  <= RESET_DATA;
            state_q.wstb  <= '0;
            state_q.pulse <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout      = state_q.data;
    assign dout_wstb = state_q.wstb;
    assign out_pulse = state_q.pulse;

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_pulse)); // R6

    generate
        for (gj = 0; gj < NUM_DOUT; gj++) begin : g_chk
            AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
                !dout_hit[gj] |=> $stable(dout[gj*8 +: 8])); // R4
            AST_WSTB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                (dout_wstb[gj] && !dout_hit[gj]) |=> !dout_wstb[gj]); // R5
        end
        for (gj = 0; gj < NUM_STB; gj++) begin : g_pchk
            AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                (out_pulse[gj] && !stb_hit[gj]) |=> !out_pulse[gj]); // R6
        end
    endgenerate
endmodule

// File: rtl/stk_io_ports.sv
module stk_io_ports
    import iop_pkg::*;
#(
    parameter int NUM_DIN   = 2,
    parameter int IN_BASE   = 0,
    parameter logic [NUM_DIN-1:0] ACK_MASK = 2'b10,
    parameter int PACK_PORT = 2,
    parameter int PACK_W    = 2,
    parameter int NUM_SR    = 2,
    parameter int SR_BASE   = 3,
    parameter int NUM_DOUT  = 3,
    parameter int OUT_BASE  = 8,
    parameter logic [NUM_DOUT*8-1:0] OUT_MASK  = 24'hFF_0F_01,
    parameter logic [NUM_DOUT*8-1:0] OUT_INIT  = 24'h00_0A_00,
    parameter logic [NUM_DOUT-1:0]   WSTB_MASK = 3'b110,
    parameter int NUM_STB   = 2,
    parameter int STB_BASE  = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_op,
    input  logic                  wr_op,
    input  logic [7:0]            port_sel,
    input  logic [7:0]            wr_data,
    output logic [7:0]            rd_data,
    input  logic [NUM_DIN*8-1:0]  din,
    output logic [NUM_DIN-1:0]    din_ack,
    input  logic [PACK_W-1:0]     pack_bits,
    input  logic [NUM_SR-1:0]     sr_set,
    output logic [NUM_DOUT*8-1:0] dout,
    output logic [NUM_DOUT-1:0]   dout_wstb,
    output logic [NUM_STB-1:0]    out_pulse
);
    logic [NUM_SR-1:0] sr_q;

    iop_sr_bits #(
        .NUM_SR (NUM_SR),
        .SR_BASE(SR_BASE)
    ) u_sr (
        .clk     (clk),
        .rst     (rst),
        .rd_op   (rd_op),
        .port_sel(port_sel),
        .sr_set  (sr_set),
        .sr_q    (sr_q)
    );

    iop_read_path #(
        .NUM_DIN  (NUM_DIN),
        .IN_BASE  (IN_BASE),
        .ACK_MASK (ACK_MASK),
        .PACK_PORT(PACK_PORT),
        .PACK_W   (PACK_W),
        .NUM_SR   (NUM_SR),
        .SR_BASE  (SR_BASE)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_op    (rd_op),
        .port_sel (port_sel),
        .din      (din),
        .pack_bits(pack_bits),
        .sr_q     (sr_q),
        .rd_data  (rd_data),
        .din_ack  (din_ack)
    );

    iop_write_path #(
        .NUM_DOUT (NUM_DOUT),
        .OUT_BASE (OUT_BASE),
        .OUT_MASK (OUT_MASK),
        .OUT_INIT (OUT_INIT),
        .WSTB_MASK(WSTB_MASK),
        .NUM_STB  (NUM_STB),
        .STB_BASE (STB_BASE)
    ) u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_op    (wr_op),
        .port_sel (port_sel),
        .wr_data  (wr_data),
        .dout     (dout),
        .dout_wstb(dout_wstb),
        .out_pulse(out_pulse)
    );

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_op && port_sel > 8'd4) |-> (rd_data == 8'h00)); // R10
endmodule

// File: tb/sim_stk_io_ports.sv
module sim_stk_io_ports;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_op = 1'b0;
    logic        wr_op = 1'b0;
    logic [7:0]  port_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] din = 16'hC3_5A;
    logic [1:0]  din_ack;
    logic [1:0]  pack_bits = 2'b10;
    logic [1:0]  sr_set = '0;
    logic [23:0] dout;
    logic [2:0]  dout_wstb;
    logic [1:0]  out_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side model
    logic [7:0] mdl_out [3];
    logic [7:0] mask_of [3];
    logic [1:0] mdl_sr;

    always #10 clk = ~clk;

    stk_io_ports u0 (
        .clk(clk), .rst(rst), .rd_op(rd_op), .wr_op(wr_op),
        .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
        .din(din), .din_ack(din_ack), .pack_bits(pack_bits), .sr_set(sr_set),
        .dout(dout), .dout_wstb(dout_wstb), .out_pulse(out_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int p);
        if (p == 0) return din[7:0];
        if (p == 1) return din[15:8];
        if (p == 2) return {6'b0, pack_bits};
        if (p == 3) return {7'b0, mdl_sr[0]};
        if (p == 4) return {7'b0, mdl_sr[1]};
        return 8'h00;
    endfunction

    function automatic logic [23:0] model_dout();
        return {mdl_out[2], mdl_out[1], mdl_out[0]};
    endfunction

    task automatic do_read(input int p, input string req);
        @(negedge clk);
        port_sel = p[7:0];
        rd_op = 1'b1;
        #1;
        check(req, {24'b0, rd_data}, {24'b0, exp_read(p)});
        @(negedge clk);
        rd_op = 1'b0;
        if (p == 3) mdl_sr[0] = sr_set[0];
        if (p == 4) mdl_sr[1] = sr_set[1];
        check("R3 ack pulse", {30'b0, din_ack}, (p == 1) ? 32'd2 : 32'd0);
        @(negedge clk);
        check("R3 ack one cycle", {30'b0, din_ack}, 32'd0);
    endtask

    task automatic do_write(input int p, input logic [7:0] v);
        logic [2:0] ew;
        logic [1:0] ep;
        @(negedge clk);
        port_sel = p[7:0];
        wr_data = v;
        wr_op = 1'b1;
        ew = '0;
        ep = '0;
        if (p >= 8 && p <= 10) begin
            mdl_out[p-8] = v & mask_of[p-8];
            ew[p-8] = (p != 8);
        end
        if (p == 12 || p == 13) ep[p-12] = 1'b1;
        @(negedge clk);
        wr_op = 1'b0;
        check("R4 R10 dout after write", {8'b0, dout}, {8'b0, model_dout()});
        check("R5 R10 write strobe", {29'b0, dout_wstb}, {29'b0, ew});
        check("R6 R10 pulse", {30'b0, out_pulse}, {30'b0, ep});
        @(negedge clk);
        check("R5 strobe one cycle", {29'b0, dout_wstb}, 32'd0);
        check("R6 pulse one cycle", {30'b0, out_pulse}, 32'd0);
        check("R4 data held", {8'b0, dout}, {8'b0, model_dout()});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mask_of[0] = 8'h01; mask_of[1] = 8'h0F; mask_of[2] = 8'hFF;
        mdl_out[0] = 8'h00; mdl_out[1] = 8'h0A; mdl_out[2] = 8'h00;
        mdl_sr = '0;
        repeat (3) @(negedge clk);
        check("R9 reset dout during reset", {8'b0, dout}, 32'h00_0A_00);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset dout", {8'b0, dout}, 32'h00_0A_00);
        check("R9 reset strobes", {27'b0, dout_wstb, out_pulse}, 32'd0);
        check("R9 reset acks", {30'b0, din_ack}, 32'd0);

        // latch 1 armed before the read sweep
        sr_set = 2'b10;
        @(negedge clk);
        sr_set = 2'b00;
        mdl_sr = 2'b10;

        // R1 R2 R7 R10: every port number read
        for (int p = 0; p < 256; p++) do_read(p, "R1 R2 R7 R10 read sweep");
        check("R7 latch cleared by read", {30'b0, mdl_sr}, 32'd0);
        do_read(4, "R7 read after clear");

        // R7 set then clear
        @(negedge clk);
        sr_set = 2'b01;
        @(negedge clk);
        sr_set = 2'b00;
        mdl_sr[0] = 1'b1;
        do_read(3, "R7 latch set");
        do_read(3, "R7 latch cleared");

        // R8 collision: read and set in same cycle
        @(negedge clk);
        port_sel = 8'd3;
        rd_op = 1'b1;
        sr_set = 2'b01;
        @(negedge clk);
        rd_op = 1'b0;
        sr_set = 2'b00;
        mdl_sr[0] = 1'b1;
        do_read(3, "R8 set wins over clear");

        // R2 packed flag positions
        pack_bits = 2'b01;
        do_read(2, "R2 empty at bit 0");
        pack_bits = 2'b11;
        do_read(2, "R2 both flags");
        din = 16'h0F_F0;
        do_read(0, "R1 new byte port 0");
        do_read(1, "R1 new byte port 1");

        // R4 R5 R6 R10: every port number written
        for (int p = 0; p < 256; p++) do_write(p, p[7:0] ^ 8'h96);
        do_write(9, 8'hFF);
        do_write(8, 8'hFE);

        // R9 reset after writes
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_out[0] = 8'h00; mdl_out[1] = 8'h0A; mdl_out[2] = 8'h00;
        @(negedge clk);
        check("R9 reset restores init", {8'b0, dout}, 32'h00_0A_00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule